// File: doc/BRIEF.md
# 8-bit ALU with Condition-Code Register

This block is the 8-bit arithmetic and logic stage of a small accumulator-based core. It takes one or two byte operands and an operation code, and returns a byte result together with an updated condition-code byte (ccr). The ALU datapath itself is combinational. The condition codes live in a register inside the block, so every accepted operation reads the flags left by the one before it. Carry chains such as ADC or SBC after ADD or SUB, and decimal adjust after a BCD add, therefore work back to back.

Operations enter on a valid/ready request channel. Each accepted operation produces exactly one result beat, one cycle later, on a valid/ready response channel. The response register holds a single entry. While it is full and the consumer holds `res_ready` low, `op_ready` stays low and the held beat does not change. The flag update takes effect on the clock edge that accepts the operation. A write-enable travels with each operation and comes back as `res_write`. Compare and test style operations never ask for a write-back, so they affect only the flags. A plain control input can load the whole ccr. For that cycle it takes priority and blocks operation intake.

Top module: `alu8_cc`

## Requirements
- R1: After reset `res_valid` is 0 and `ccr` is 8'hFF. The ccr bits, from bit 7 down to bit 0, are S, X, H, I, N, Z, V, C.
- R2: `op_ready` is low only while `res_valid` is high and `res_ready` is low, or while `ccr_load` is high. An accepted operation sets `res_valid` on the next edge. A stalled beat keeps `res_valid`, `res_data` and `res_write` stable.
- R3: ADD (code 0) returns a+b and ADC (code 1) returns a+b+C. For both, H is the carry from bit 3 into bit 4, C is the carry out of bit 7, and V is set when a and b have the same sign and the result sign differs from them.
- R4: SUB (code 2) returns a-b and SBC (code 3) returns a-b-C. C is the borrow, V is set when a and b differ in sign and the result sign differs from a, and H is kept. CMP (code 4) sets the flags as SUB does.
- R5: AND (5), OR (6), EOR (7), BIT (8, flags of AND) and LOAD (22, result is b) set N and Z from the result, clear V and keep C.
- R6: INC (9) and DEC (10) keep C. INC sets V only for a=8'h7F, and DEC sets V only for a=8'h80. NEG (12'd11, result 0-a) sets V only for a=8'h80 and sets C when a is nonzero.
- R7: COM (12) returns ~a with V=0 and C=1. CLR (13) returns 0 with N=0, Z=1, V=0, C=0. TST (14) returns a with V=0 and C=0. SEXT (20) returns 8'hFF if a[7] is set and 8'h00 otherwise, with V=0 and C=0.
- R8: ASL (15) fills bit 0 with 0, ASR (16) copies bit 7, LSR (17) fills bit 7 with 0, ROL (18) takes the old C into bit 0, and ROR (19) takes the old C into bit 7. The bit shifted out goes to C, and V equals the new N xor the new C.
- R9: DAA (21) adds 8'h06 when a[3:0]>9 or H=1. It adds 8'h60 when a[7:4]>9, when C=1, or when a[7:4]=9 and a[3:0]>9. C becomes the correction carry or the old C, and V is cleared.
- R10: No operation changes S, X or I. H changes only under ADD and ADC. For every operation, N is bit 7 of the result and Z is set when the result is zero.
- R11: `res_write` equals the `wr_en` given with the operation, except that CMP, BIT and TST always return 0.
- R12: When `ccr_load` is high at an edge, ccr takes `ccr_wdata` and no operation is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Block can take an operation |
| op_code | input | 5 | Operation select |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| wr_en | input | 1 | Requested result write-back |
| ccr_load | input | 1 | Load the condition codes directly |
| ccr_wdata | input | 8 | Value for a direct ccr load |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Consumer takes the result beat |
| res_data | output | 8 | Result byte |
| res_write | output | 1 | Result should be written back |
| ccr | output | 8 | Current condition-code register |

## Verification
A wrong flag stored in the ccr register is visible on the `ccr` port on the edge after the operation that produced it. It also corrupts the next carry-consuming operation (ADC, SBC, ROL, ROR, DAA), so chained vectors expose it within two operations. A wrong occupancy state in the response register shows up at once as a dropped or duplicated beat, or as a beat that changes while stalled. The directed scenarios therefore chain operations through carry and half-carry, and hold the consumer off for several cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int W      = 8;
  localparam int NIB    = W / 2;
  localparam int OPW    = 5;
  localparam int CC_C   = 0;
  localparam int CC_V   = 1;
  localparam int CC_Z   = 2;
  localparam int CC_N   = 3;
  localparam int CC_I   = 4;
  localparam int CC_H   = 5;
  localparam logic [W-1:0] CCR_RESET = '1;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_EOR  = 5'd7,
    OP_BIT  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_NEG  = 5'd11,
    OP_COM  = 5'd12, OP_CLR  = 5'd13, OP_TST  = 5'd14, OP_ASL  = 5'd15,
    OP_ASR  = 5'd16, OP_LSR  = 5'd17, OP_ROL  = 5'd18, OP_ROR  = 5'd19,
    OP_SEXT = 5'd20, OP_DAA  = 5'd21, OP_LOAD = 5'd22
  } alu_op_e;

  typedef struct packed {
    logic [W-1:0] res;
    logic         h;
    logic         n;
    logic         z;
    logic         v;
    logic         c;
  } alu_res_t;

  function automatic logic is_arith(alu_op_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
                      OP_INC, OP_DEC, OP_NEG, OP_DAA};
  endfunction

  function automatic logic is_logic(alu_op_e op);
    return op inside {OP_AND, OP_OR, OP_EOR, OP_BIT, OP_LOAD,
                      OP_COM, OP_CLR, OP_TST, OP_SEXT};
  endfunction

  function automatic logic is_shift(alu_op_e op);
    return op inside {OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR};
  endfunction

  function automatic logic flags_only(alu_op_e op);
    return op inside {OP_CMP, OP_BIT, OP_TST};
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  logic         h_in,
  output alu_res_t     o
);
  localparam logic [NIB-1:0] BCD_MAX = NIB'(9);
  localparam logic [NIB-1:0] BCD_FIX = NIB'(6);

  logic [W:0]     wide;
  logic [NIB:0]   low_sum;
  logic           ci;
  logic           lo_big;
  logic           fix_lo;
  logic           fix_hi;

  always_comb begin
    wide    = '0;
    low_sum = '0;
    ci      = 1'b0;
    lo_big  = a[NIB-1:0] > BCD_MAX;
    fix_lo  = lo_big || h_in;
    fix_hi  = (a[W-1:NIB] > BCD_MAX) || c_in ||
              ((a[W-1:NIB] == BCD_MAX) && lo_big);
    o.res   = a;
    o.h     = h_in;
    o.v     = 1'b0;
    o.c     = c_in;
    case (op)
      OP_ADD, OP_ADC: begin
        ci      = (op == OP_ADC) && c_in;
        wide    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        low_sum = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, ci};
        o.res   = wide[W-1:0];
        o.h     = low_sum[NIB];
        o.c     = wide[W];
        o.v     = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ci    = (op == OP_SBC) && c_in;
        wide  = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ci};
        o.res = wide[W-1:0];
        o.c   = wide[W];
        o.v   = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
      end
      OP_INC: begin
        o.res = a + 1'b1;
        o.v   = (a == {1'b0, {(W-1){1'b1}}});
      end
      OP_DEC: begin
        o.res = a - 1'b1;
        o.v   = (a == {1'b1, {(W-1){1'b0}}});
      end
      OP_NEG: begin
        o.res = '0 - a;
        o.v   = (a == {1'b1, {(W-1){1'b0}}});
        o.c   = (a != '0);
      end
      OP_DAA: begin
        wide  = {1'b0, a} + {1'b0, (fix_hi ? BCD_FIX : '0), (fix_lo ? BCD_FIX : '0)};
        o.res = wide[W-1:0];
        o.c   = wide[W] || c_in;
      end
      default: ;
    endcase
    o.n = o.res[W-1];
    o.z = (o.res == '0);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  logic         h_in,
  output alu_res_t     o
);
  always_comb begin
    o.res = a;
    o.h   = h_in;
    o.v   = 1'b0;
    o.c   = c_in;
    case (op)
      OP_AND, OP_BIT: o.res = a & b;
      OP_OR:          o.res = a | b;
      OP_EOR:         o.res = a ^ b;
      OP_LOAD:        o.res = b;
      OP_COM: begin
        o.res = ~a;
        o.c   = 1'b1;
      end
      OP_CLR: begin
        o.res = '0;
        o.c   = 1'b0;
      end
      OP_TST:  o.c = 1'b0;
      OP_SEXT: begin
        o.res = {W{a[W-1]}};
        o.c   = 1'b0;
      end
      default: ;
    endcase
    o.n = o.res[W-1];
    o.z = (o.res == '0);
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         c_in,
  input  logic         h_in,
  output alu_res_t     o
);
  always_comb begin
    o.res = a;
    o.h   = h_in;
    o.c   = c_in;
    case (op)
      OP_ASL: begin o.res = {a[W-2:0], 1'b0};   o.c = a[W-1]; end
      OP_ROL: begin o.res = {a[W-2:0], c_in};   o.c = a[W-1]; end
      OP_ASR: begin o.res = {a[W-1], a[W-1:1]}; o.c = a[0];   end
      OP_LSR: begin o.res = {1'b0, a[W-1:1]};   o.c = a[0];   end
      OP_ROR: begin o.res = {c_in, a[W-1:1]};   o.c = a[0];   end
      default: ;
    endcase
    o.n = o.res[W-1];
    o.z = (o.res == '0);
    o.v = o.n ^ o.c;
  end
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           wr_en,
  input  logic           ccr_load,
  input  logic [W-1:0]   ccr_wdata,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [W-1:0]   res_data,
  output logic           res_write,
  output logic [W-1:0]   ccr
);
  alu_op_e      op;
  alu_res_t     arith_o, logic_o, shift_o, pick;
  logic [W-1:0] ccr_q, ccr_next, res_q;
  logic         rv_q, rw_q, accept, known;

  assign op = alu_op_e'(op_code);

  alu8_arith u_arith (
    .op(op), .a(op_a), .b(op_b),
    .c_in(ccr_q[CC_C]), .h_in(ccr_q[CC_H]), .o(arith_o)
  );
  alu8_logic u_logic (
    .op(op), .a(op_a), .b(op_b),
    .c_in(ccr_q[CC_C]), .h_in(ccr_q[CC_H]), .o(logic_o)
  );
  alu8_shift u_shift (
    .op(op), .a(op_a),
    .c_in(ccr_q[CC_C]), .h_in(ccr_q[CC_H]), .o(shift_o)
  );

  always_comb begin
    known = 1'b1;
    if (is_arith(op))      pick = arith_o;
    else if (is_logic(op)) pick = logic_o;
    else if (is_shift(op)) pick = shift_o;
    else begin
      known = 1'b0;
      pick  = '{res: op_a, h: ccr_q[CC_H], n: ccr_q[CC_N],
                z: ccr_q[CC_Z], v: ccr_q[CC_V], c: ccr_q[CC_C]};
    end
    ccr_next           = ccr_q;
    ccr_next[CC_H]     = pick.h;
    ccr_next[CC_N]     = pick.n;
    ccr_next[CC_Z]     = pick.z;
    ccr_next[CC_V]     = pick.v;
    ccr_next[CC_C]     = pick.c;
  end

  assign op_ready = (!rv_q || res_ready) && !ccr_load;
  assign accept   = op_valid && op_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= CCR_RESET;
      rv_q  <= 1'b0;
      res_q <= '0;
      rw_q  <= 1'b0;
    end else begin
      if (ccr_load)    ccr_q <= ccr_wdata;
      else if (accept) ccr_q <= ccr_next;
      if (accept) begin
        rv_q  <= 1'b1;
        res_q <= pick.res;
        rw_q  <= wr_en && known && !flags_only(op);
      end else if (res_ready) begin
        rv_q  <= 1'b0;
      end
    end
  end

  assign res_valid = rv_q;
  assign res_data  = res_q;
  assign res_write = rw_q;
  assign ccr       = ccr_q;
endmodule

// File: rtl/alu8_cc_chk.sv
module alu8_cc_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic           op_ready,
  input logic [OPW-1:0] op_code,
  input logic [W-1:0]   op_a,
  input logic           ccr_load,
  input logic [W-1:0]   ccr_wdata,
  input logic           res_valid,
  input logic           res_ready,
  input logic [W-1:0]   res_data,
  input logic           res_write,
  input logic [W-1:0]   ccr
);
  logic acc;
  assign acc = op_valid && op_ready;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (ccr == CCR_RESET) && !res_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_write));

  p_beat_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);

  p_com_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code == OP_COM) |=> (ccr[CC_V:CC_C] == 2'b01) && (res_data == ~$past(op_a)));

  p_shift_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code inside {OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR})
    |=> ccr[CC_V] == (ccr[CC_N] ^ ccr[CC_C]));

  p_sxi_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (ccr[7:6] == $past(ccr[7:6])) && (ccr[CC_I] == $past(ccr[CC_I])));

  p_flag_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code inside {OP_CMP, OP_BIT, OP_TST}) |=> !res_write);

  p_direct_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_load |=> ccr == $past(ccr_wdata));
endmodule

bind alu8_cc alu8_cc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .op_a(op_a), .ccr_load(ccr_load), .ccr_wdata(ccr_wdata),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .res_write(res_write), .ccr(ccr)
);

// File: tb/tb_alu8_cc.sv
`timescale 1ns/100ps
module tb_alu8_cc;
  localparam logic [4:0] ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, ANDO=5, ORO=6,
    EOR=7, BITO=8, INC=9, DEC=10, NEG=11, COM=12, CLR=13, TST=14, ASL=15,
    ASR=16, LSR=17, ROL=18, ROR=19, SEXT=20, DAA=21, LOAD=22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, wr_en = 1'b0, ccr_load = 1'b0, res_ready = 1'b1;
  logic [4:0] op_code = '0;
  logic [7:0] op_a = '0, op_b = '0, ccr_wdata = '0;
  logic op_ready, res_valid, res_write;
  logic [7:0] res_data, ccr;
  logic [7:0] mccr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_cc dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .wr_en(wr_en),
    .ccr_load(ccr_load), .ccr_wdata(ccr_wdata), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_write(res_write), .ccr(ccr)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Reference built from the requirement text: returns {result, ccr}
  function automatic logic [15:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] cc);
    logic [7:0] r; logic h, v, c; int ci, s, lo, hi, adj;
    r = a; h = cc[5]; v = cc[1]; c = cc[0];
    ci = ((op == ADC || op == SBC) && cc[0]) ? 1 : 0;
    case (op)
      ADD, ADC: begin
        s = int'(a) + int'(b) + ci; r = 8'(s); c = s > 255;
        h = (int'(a[3:0]) + int'(b[3:0]) + ci) > 15;
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      SUB, SBC, CMP: begin
        s = int'(a) - int'(b) - ci; r = 8'(s); c = s < 0;
        v = (a[7] != b[7]) && (r[7] != a[7]);
      end
      ANDO, BITO: begin r = a & b; v = 0; end
      ORO:  begin r = a | b; v = 0; end
      EOR:  begin r = a ^ b; v = 0; end
      LOAD: begin r = b; v = 0; end
      INC:  begin r = a + 8'd1; v = (a == 8'h7F); end
      DEC:  begin r = a - 8'd1; v = (a == 8'h80); end
      NEG:  begin r = 8'd0 - a; v = (a == 8'h80); c = (a != 0); end
      COM:  begin r = ~a; v = 0; c = 1; end
      CLR:  begin r = 0; v = 0; c = 0; end
      TST:  begin v = 0; c = 0; end
      SEXT: begin r = a[7] ? 8'hFF : 8'h00; v = 0; c = 0; end
      ASL:  begin c = a[7]; r = {a[6:0], 1'b0}; v = r[7] ^ c; end
      ROL:  begin c = a[7]; r = {a[6:0], cc[0]}; v = r[7] ^ c; end
      ASR:  begin c = a[0]; r = {a[7], a[7:1]}; v = r[7] ^ c; end
      LSR:  begin c = a[0]; r = {1'b0, a[7:1]}; v = r[7] ^ c; end
      ROR:  begin c = a[0]; r = {cc[0], a[7:1]}; v = r[7] ^ c; end
      DAA: begin
        lo = int'(a[3:0]); hi = int'(a[7:4]); adj = 0;
        if (lo > 9 || cc[5]) adj += 6;
        if (hi > 9 || cc[0] || (hi == 9 && lo > 9)) adj += 96;
        s = int'(a) + adj; r = 8'(s); c = (s > 255) || cc[0]; v = 0;
      end
      default: ;
    endcase
    return {r, cc[7:6], h, cc[4], r[7], (r == 8'd0), v, c};
  endfunction

  task automatic do_op(input string tag, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic we);
    logic [15:0] e;
    e = model(op, a, b, mccr);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_a = a; op_b = b; wr_en = we;
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " valid"}, {7'd0, res_valid}, 8'd1);
    chk({tag, " result"}, res_data, e[15:8]);
    chk({tag, " ccr"}, ccr, e[7:0]);
    chk("R11 write flag", {7'd0, res_write},
        {7'd0, we && !(op == CMP || op == BITO || op == TST)});
    mccr = e[7:0];
  endtask

  task automatic set_ccr(input logic [7:0] v);
    @(negedge clk);
    ccr_load = 1'b1; ccr_wdata = v;
    @(negedge clk);
    ccr_load = 1'b0;
    mccr = v;
    chk("R12 direct load", ccr, v);
  endtask

  task automatic t_reset();
    chk("R1 ccr after reset", ccr, 8'hFF);
    chk("R1 no beat after reset", {7'd0, res_valid}, 8'd0);
  endtask

  task automatic t_add();
    set_ccr(8'h00);
    do_op("R3 add plain", ADD, 8'h25, 8'h38, 1);
    do_op("R3 add overflow", ADD, 8'h7F, 8'h01, 1);
    chk("R3 half carry and V", ccr & 8'h2B, 8'h2A);
    do_op("R3 add wrap", ADD, 8'hFF, 8'h01, 1);
    do_op("R3 adc with carry", ADC, 8'h10, 8'h20, 1);
    chk("R3 adc sum", res_data, 8'h31);
  endtask

  task automatic t_sub();
    set_ccr(8'h20);
    do_op("R4 sub borrow", SUB, 8'h10, 8'h20, 1);
    do_op("R4 sbc borrow in", SBC, 8'h10, 8'h05, 1);
    chk("R4 sbc value", res_data, 8'h0A);
    do_op("R4 sub overflow", SUB, 8'h80, 8'h01, 1);
    do_op("R4 cmp equal", CMP, 8'h55, 8'h55, 1);
    chk("R4 cmp zero flag", ccr & 8'h0F, 8'h04);
  endtask

  task automatic t_logic();
    set_ccr(8'h03);
    do_op("R5 and keeps C", ANDO, 8'hF0, 8'h3C, 1);
    do_op("R5 or", ORO, 8'h80, 8'h01, 1);
    do_op("R5 eor zero", EOR, 8'hA5, 8'hA5, 1);
    do_op("R5 bit", BITO, 8'h0F, 8'h80, 1);
    do_op("R5 load", LOAD, 8'h00, 8'h9C, 1);
    chk("R5 carry kept", ccr & 8'h03, 8'h01);
  endtask

  task automatic t_incdec();
    set_ccr(8'h01);
    do_op("R6 inc 7F", INC, 8'h7F, 8'h00, 1);
    do_op("R6 inc FF", INC, 8'hFF, 8'h00, 1);
    do_op("R6 dec 80", DEC, 8'h80, 8'h00, 1);
    do_op("R6 neg 80", NEG, 8'h80, 8'h00, 1);
    do_op("R6 neg 00", NEG, 8'h00, 8'h00, 1);
    do_op("R6 neg 01", NEG, 8'h01, 8'h00, 1);
  endtask

  task automatic t_unary();
    set_ccr(8'h02);
    do_op("R7 com", COM, 8'h5A, 8'h00, 1);
    do_op("R7 clr", CLR, 8'h77, 8'h00, 1);
    chk("R7 clr flags", ccr & 8'h0F, 8'h04);
    set_ccr(8'h03);
    do_op("R7 tst", TST, 8'h90, 8'h00, 1);
    do_op("R7 sext neg", SEXT, 8'h81, 8'h00, 1);
    do_op("R7 sext pos", SEXT, 8'h7F, 8'h00, 1);
  endtask

  task automatic t_shift();
    set_ccr(8'h00);
    do_op("R8 asl", ASL, 8'hC1, 8'h00, 1);
    do_op("R8 rol carry in", ROL, 8'h40, 8'h00, 1);
    do_op("R8 asr", ASR, 8'h81, 8'h00, 1);
    do_op("R8 lsr", LSR, 8'h01, 8'h00, 1);
    do_op("R8 ror carry in", ROR, 8'h02, 8'h00, 1);
    chk("R8 ror value", res_data, 8'h81);
  endtask

  task automatic t_daa();
    set_ccr(8'h00);
    do_op("R9 bcd add", ADD, 8'h25, 8'h38, 1);
    do_op("R9 adjust low", DAA, res_data, 8'h00, 1);
    chk("R9 25+38", res_data, 8'h63);
    do_op("R9 bcd add 99", ADD, 8'h99, 8'h01, 1);
    do_op("R9 adjust both", DAA, res_data, 8'h00, 1);
    chk("R9 99+01 carry", {res_data[7:0]}, 8'h00);
    chk("R9 carry out", ccr & 8'h01, 8'h01);
    do_op("R9 half carry", ADD, 8'h09, 8'h09, 1);
    do_op("R9 adjust by H", DAA, res_data, 8'h00, 1);
    chk("R9 09+09", res_data, 8'h18);
  endtask

  task automatic t_keep();
    set_ccr(8'hD0);
    do_op("R10 add", ADD, 8'h08, 8'h08, 1);
    do_op("R10 sub keeps H", SUB, 8'h01, 8'h02, 1);
    do_op("R10 rol", ROL, 8'h80, 8'h00, 1);
    chk("R10 S X I held", ccr & 8'hF0, 8'hF0);
  endtask

  task automatic t_write();
    set_ccr(8'h00);
    do_op("R11 add no write", ADD, 8'h01, 8'h01, 0);
    do_op("R11 tst", TST, 8'h01, 8'h00, 1);
    do_op("R11 bit", BITO, 8'h01, 8'h01, 1);
    do_op("R11 add write", ADD, 8'h01, 8'h01, 1);
  endtask

  task automatic t_load();
    @(negedge clk);
    ccr_load = 1'b1; ccr_wdata = 8'h5A;
    op_valid = 1'b1; op_code = CLR; op_a = 8'h11; wr_en = 1'b1;
    #1 chk("R12 intake blocked", {7'd0, op_ready}, 8'd0);
    @(negedge clk);
    ccr_load = 1'b0; op_valid = 1'b0;
    chk("R12 ccr loaded", ccr, 8'h5A);
    chk("R12 no beat", {7'd0, res_valid}, 8'd0);
    mccr = 8'h5A;
  endtask

  task automatic t_stall();
    logic [15:0] e;
    set_ccr(8'h00);
    e = model(ADD, 8'h33, 8'h44, mccr);
    @(negedge clk);
    res_ready = 1'b0;
    op_valid = 1'b1; op_code = ADD; op_a = 8'h33; op_b = 8'h44; wr_en = 1'b1;
    @(negedge clk);
    op_code = SUB; op_a = 8'h00; op_b = 8'h01;
    chk("R2 beat out", {7'd0, res_valid}, 8'd1);
    chk("R2 ready low when full", {7'd0, op_ready}, 8'd0);
    repeat (3) @(negedge clk);
    chk("R2 held data", res_data, e[15:8]);
    chk("R2 held valid", {7'd0, res_valid}, 8'd1);
    chk("R2 flags not moved", ccr, e[7:0]);
    op_valid = 1'b0;
    res_ready = 1'b1;
    #1 chk("R2 ready back", {7'd0, op_ready}, 8'd1);
    @(negedge clk);
    chk("R2 beat drained", {7'd0, res_valid}, 8'd0);
    mccr = e[7:0];
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mccr = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_unary();
    t_shift();
    t_daa();
    t_keep();
    t_write();
    t_load();
    t_stall();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule